// File: doc/BRIEF.md
# Integer and Load-Store Instruction Decoder

This block turns one raw 32-bit instruction word of a Power-style RISC instruction set into the control fields that an issue stage needs. It handles a small integer subset: add, and and or in register-register and register-immediate forms, plus word, halfword and byte loads and stores. Loads and stores come in displacement form, in update form, and in indexed form for words. For each word it reports an operation class, the register numbers for one write port and three read ports with their valid flags, a sign- or zero-extended immediate and the mode that produced it, the record flag, the update flag and the memory access length in bytes.

A byte-order input selects how the word is read. When the input is high, the word is decoded as given. When it is low, the four bytes are reversed first. The decode itself is combinational. A parameter places an optional register stage after it, so that the decoder can sit at a pipeline boundary. With the default settings the outputs follow the input by one clock.

Top module: `idec_top`

## Requirements
- R1: With `big_endian_i` = 1 the word on `insn_i` is decoded unchanged. With `big_endian_i` = 0, input bits 7..0 are decoded as bits 31..24, bits 15..8 as 23..16, bits 23..16 as 15..8 and bits 31..24 as 7..0.
- R2: The primary opcode is bits 31..26. When it is 31, the extended opcode in bits 10..1 selects the operation: 266 add, 28 and, 444 or, 23 indexed word load, 151 indexed word store. `op_o` encodes 0 nop, 1 add, 2 and, 3 or, 4 load, 5 store, 7 illegal.
- R3: `imm_mode_o` encodes 0 none, 1 unsigned low, 2 unsigned high, 3 signed low, 4 signed high. Take the 16-bit field in bits 15..0. Unsigned low zero-extends it to XLEN bits. Signed low sign-extends it from bit 15. Signed high places it at bits 31..16 and sign-extends from bit 31. Unsigned high places it at bits 31..16 with zeros above. In mode none, `imm_o` is 0.
- R4: Primary opcodes 14 and 15 (add immediate, add immediate shifted) give op add. They write the register in bits 25..21 and read the register in bits 20..16 on port 1. They use the signed low and signed high mode respectively, with the record flag clear.
- R5: Primary opcodes 24 (or immediate) and 28 (and immediate, record form) give op or and op and. They write the register in bits 20..16 and present bits 25..21 on read port 3, using unsigned low mode. The record flag is 0 for opcode 24 and always 1 for opcode 28.
- R6: The exact word 0x60000000, after byte ordering, gives op nop with every valid flag, the immediate, the mode, the record flag, the update flag and the length all 0. Any other opcode-24 word decodes as an or.
- R7: The extended add writes bits 25..21 and reads bits 20..16 on port 1 and bits 15..11 on port 2. The extended and and or write bits 20..16 and read bits 25..21 on port 3 and bits 15..11 on port 2. All three take the record flag from bit 0 and use immediate mode none.
- R8: Displacement loads have primary opcodes 32 (word), 33 (word with update), 34 (byte) and 40 (halfword). They give op load, write bits 25..21, read the base in bits 20..16 on port 1 and use signed low mode. `len_o` is 4, 4, 1 and 2 respectively, and `upd_o` is 1 only for opcode 33.
- R9: Displacement stores have primary opcodes 36 (word), 37 (word with update), 38 (byte) and 44 (halfword). They give op store, keep the write port invalid, present the source in bits 25..21 on port 3 and the base in bits 20..16 on port 1, and use signed low mode. `len_o` is 4, 4, 1 and 2 respectively, and `upd_o` is 1 only for opcode 37.
- R10: The indexed word load writes bits 25..21. The indexed word store presents bits 25..21 on port 3 and leaves the write port invalid. Both read bits 20..16 on port 1 and the index in bits 15..11 on port 2, with length 4, update 0, record 0 whatever bit 0 holds, and mode none.
- R11: Every other word gives op illegal with all valid flags low and the immediate, mode, record, update and length outputs 0.
- R12: With `REG_OUT` = 1, the outputs show the decode of the input sampled at the previous rising clock edge. While `rst_n` is low, all outputs are held at 0 (op nop) whatever the input.
- R13: A register-number output whose valid flag is low reads 0, and `len_o` and `upd_o` are 0 for every operation that is neither a load nor a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| insn_i | input | 32 | Raw instruction word |
| big_endian_i | input | 1 | 1: decode as given; 0: reverse byte order first |
| op_o | output | 3 | Operation class |
| wr_en_o | output | 1 | Write port valid |
| wr_reg_o | output | 5 | Write register number |
| rd1_en_o | output | 1 | Read port 1 valid |
| rd1_reg_o | output | 5 | Read port 1 register number |
| rd2_en_o | output | 1 | Read port 2 valid |
| rd2_reg_o | output | 5 | Read port 2 register number |
| rd3_en_o | output | 1 | Read port 3 valid |
| rd3_reg_o | output | 5 | Read port 3 register number |
| imm_o | output | XLEN (64) | Extended immediate |
| imm_mode_o | output | 3 | Immediate extension mode |
| rc_o | output | 1 | Record flag |
| upd_o | output | 1 | Base register update flag |
| len_o | output | 4 | Access length in bytes |

## Verification
The hardest case to reach from the ports is the single nop word. It differs from an ordinary or-immediate only in that every field is zero, so random operands almost never produce it. The stimulus therefore sends it on purpose in both byte orders. Next to it the stimulus sends or-immediate words that differ from it by a single bit, and the little-endian image of the nop word with the byte-order input set high. Random operand fields cover the rest of the subset in both byte orders, and negative displacements exercise sign extension through bit 63.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int REG_W  = 5;
    localparam int INSN_W = 32;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ADD     = 3'd1,
        OP_AND     = 3'd2,
        OP_OR      = 3'd3,
        OP_LOAD    = 3'd4,
        OP_STORE   = 3'd5,
        OP_ILLEGAL = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        IMM_NONE = 3'd0,
        IMM_ULO  = 3'd1,
        IMM_UHI  = 3'd2,
        IMM_SLO  = 3'd3,
        IMM_SHI  = 3'd4
    } imm_e;

    typedef struct packed {
        op_e              op;
        logic             wr_en;
        logic [REG_W-1:0] wr;
        logic             rd1_en;
        logic [REG_W-1:0] rd1;
        logic             rd2_en;
        logic [REG_W-1:0] rd2;
        logic             rd3_en;
        logic [REG_W-1:0] rd3;
        imm_e             mode;
        logic             rc;
        logic             upd;
        logic [3:0]       len;
    } ctl_t;

    localparam logic [5:0] PO_ADDI  = 6'd14;
    localparam logic [5:0] PO_ADDIS = 6'd15;
    localparam logic [5:0] PO_ORI   = 6'd24;
    localparam logic [5:0] PO_ANDIR = 6'd28;
    localparam logic [5:0] PO_EXT   = 6'd31;
    localparam logic [5:0] PO_LWZ   = 6'd32;
    localparam logic [5:0] PO_LWZU  = 6'd33;
    localparam logic [5:0] PO_LBZ   = 6'd34;
    localparam logic [5:0] PO_STW   = 6'd36;
    localparam logic [5:0] PO_STWU  = 6'd37;
    localparam logic [5:0] PO_STB   = 6'd38;
    localparam logic [5:0] PO_LHZ   = 6'd40;
    localparam logic [5:0] PO_STH   = 6'd44;

    localparam logic [9:0] XO_ADD  = 10'd266;
    localparam logic [9:0] XO_AND  = 10'd28;
    localparam logic [9:0] XO_OR   = 10'd444;
    localparam logic [9:0] XO_LWZX = 10'd23;
    localparam logic [9:0] XO_STWX = 10'd151;

    localparam logic [INSN_W-1:0] NOP_WORD = 32'h6000_0000;

endpackage

// File: rtl/idec_order.sv
// Byte-order normaliser: reverses byte lanes when the word is little-endian.
module idec_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] raw_i,
    input  logic         big_endian_i,
    output logic [W-1:0] word_o
);
    localparam int NB = W / 8;

    logic [W-1:0] swapped;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign swapped[8*b +: 8] = raw_i[8*(NB-1-b) +: 8];
    end

    assign word_o = big_endian_i ? raw_i : swapped;
endmodule

// File: rtl/idec_ctl.sv
// Field decode: operation class, register routing, flags, immediate mode.
module idec_ctl
    import idec_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    output ctl_t              ctl_o,
    output logic [15:0]       field_o
);
    logic [5:0]       prim;
    logic [9:0]       xo;
    logic [REG_W-1:0] f_hi;
    logic [REG_W-1:0] f_mid;
    logic [REG_W-1:0] f_lo;
    logic             rbit;

    assign prim    = word_i[31:26];
    assign xo      = word_i[10:1];
    assign f_hi    = word_i[25:21];
    assign f_mid   = word_i[20:16];
    assign f_lo    = word_i[15:11];
    assign rbit    = word_i[0];
    assign field_o = word_i[15:0];

    always_comb begin
        ctl_o    = '0;
        ctl_o.op = OP_ILLEGAL;
        case (prim)
            PO_ADDI, PO_ADDIS: begin
                ctl_o.op     = OP_ADD;
                ctl_o.wr_en  = 1'b1;
                ctl_o.wr     = f_hi;
                ctl_o.rd1_en = 1'b1;
                ctl_o.rd1    = f_mid;
                ctl_o.mode   = (prim == PO_ADDIS) ? IMM_SHI : IMM_SLO;
            end
            PO_ORI, PO_ANDIR: begin
                ctl_o.op     = (prim == PO_ORI) ? OP_OR : OP_AND;
                ctl_o.wr_en  = 1'b1;
                ctl_o.wr     = f_mid;
                ctl_o.rd3_en = 1'b1;
                ctl_o.rd3    = f_hi;
                ctl_o.mode   = IMM_ULO;
                ctl_o.rc     = (prim == PO_ANDIR);
            end
            PO_LWZ, PO_LWZU, PO_LBZ, PO_LHZ: begin
                ctl_o.op     = OP_LOAD;
                ctl_o.wr_en  = 1'b1;
                ctl_o.wr     = f_hi;
                ctl_o.rd1_en = 1'b1;
                ctl_o.rd1    = f_mid;
                ctl_o.mode   = IMM_SLO;
                ctl_o.upd    = (prim == PO_LWZU);
                ctl_o.len    = (prim == PO_LBZ) ? 4'd1 :
                               (prim == PO_LHZ) ? 4'd2 : 4'd4;
            end
            PO_STW, PO_STWU, PO_STB, PO_STH: begin
                ctl_o.op     = OP_STORE;
                ctl_o.rd1_en = 1'b1;
                ctl_o.rd1    = f_mid;
                ctl_o.rd3_en = 1'b1;
                ctl_o.rd3    = f_hi;
                ctl_o.mode   = IMM_SLO;
                ctl_o.upd    = (prim == PO_STWU);
                ctl_o.len    = (prim == PO_STB) ? 4'd1 :
                               (prim == PO_STH) ? 4'd2 : 4'd4;
            end
            PO_EXT: begin
                case (xo)
                    XO_ADD: begin
                        ctl_o.op     = OP_ADD;
                        ctl_o.wr_en  = 1'b1;
                        ctl_o.wr     = f_hi;
                        ctl_o.rd1_en = 1'b1;
                        ctl_o.rd1    = f_mid;
                        ctl_o.rd2_en = 1'b1;
                        ctl_o.rd2    = f_lo;
                        ctl_o.rc     = rbit;
                    end
                    XO_AND, XO_OR: begin
                        ctl_o.op     = (xo == XO_OR) ? OP_OR : OP_AND;
                        ctl_o.wr_en  = 1'b1;
                        ctl_o.wr     = f_mid;
                        ctl_o.rd3_en = 1'b1;
                        ctl_o.rd3    = f_hi;
                        ctl_o.rd2_en = 1'b1;
                        ctl_o.rd2    = f_lo;
                        ctl_o.rc     = rbit;
                    end
                    XO_LWZX, XO_STWX: begin
                        ctl_o.rd1_en = 1'b1;
                        ctl_o.rd1    = f_mid;
                        ctl_o.rd2_en = 1'b1;
                        ctl_o.rd2    = f_lo;
                        ctl_o.len    = 4'd4;
                        if (xo == XO_LWZX) begin
                            ctl_o.op    = OP_LOAD;
                            ctl_o.wr_en = 1'b1;
                            ctl_o.wr    = f_hi;
                        end else begin
                            ctl_o.op     = OP_STORE;
                            ctl_o.rd3_en = 1'b1;
                            ctl_o.rd3    = f_hi;
                        end
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
        if (word_i == NOP_WORD) begin
            ctl_o = '0;
        end
    end
endmodule

// File: rtl/idec_imm.sv
// Immediate extension in one of four modes.
module idec_imm
    import idec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [15:0]     field_i,
    input  imm_e            mode_i,
    output logic [XLEN-1:0] imm_o
);
    logic [31:0] shifted;

    assign shifted = {field_i, 16'h0000};

    always_comb begin
        unique case (mode_i)
            IMM_ULO: imm_o = XLEN'(field_i);
            IMM_UHI: imm_o = XLEN'(shifted);
            IMM_SLO: imm_o = XLEN'($signed(field_i));
            IMM_SHI: imm_o = XLEN'($signed(shifted));
            default: imm_o = '0;
        endcase
    end
endmodule

// File: rtl/idec_top.sv
module idec_top
    import idec_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       insn_i,
    input  logic              big_endian_i,
    output logic [2:0]        op_o,
    output logic              wr_en_o,
    output logic [4:0]        wr_reg_o,
    output logic              rd1_en_o,
    output logic [4:0]        rd1_reg_o,
    output logic              rd2_en_o,
    output logic [4:0]        rd2_reg_o,
    output logic              rd3_en_o,
    output logic [4:0]        rd3_reg_o,
    output logic [XLEN-1:0]   imm_o,
    output logic [2:0]        imm_mode_o,
    output logic              rc_o,
    output logic              upd_o,
    output logic [3:0]        len_o
);
    typedef struct packed {
        ctl_t            ctl;
        logic [XLEN-1:0] imm;
    } dec_t;

    logic [INSN_W-1:0] word;
    logic [15:0]       field;
    dec_t              dec_d;
    dec_t              dec_q;

    idec_order #(.W(INSN_W)) u_order (
        .raw_i        (insn_i),
        .big_endian_i (big_endian_i),
        .word_o       (word)
    );

    idec_ctl u_ctl (
        .word_i  (word),
        .ctl_o   (dec_d.ctl),
        .field_o (field)
    );

    idec_imm #(.XLEN(XLEN)) u_imm (
        .field_i (field),
        .mode_i  (dec_d.ctl.mode),
        .imm_o   (dec_d.imm)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dec_q <= '0;
            end else begin
                dec_q <= dec_d;
            end
        end
    end else begin : g_comb
        assign dec_q = dec_d;
    end

    assign op_o       = dec_q.ctl.op;
    assign wr_en_o    = dec_q.ctl.wr_en;
    assign wr_reg_o   = dec_q.ctl.wr;
    assign rd1_en_o   = dec_q.ctl.rd1_en;
    assign rd1_reg_o  = dec_q.ctl.rd1;
    assign rd2_en_o   = dec_q.ctl.rd2_en;
    assign rd2_reg_o  = dec_q.ctl.rd2;
    assign rd3_en_o   = dec_q.ctl.rd3_en;
    assign rd3_reg_o  = dec_q.ctl.rd3;
    assign imm_o      = dec_q.imm;
    assign imm_mode_o = dec_q.ctl.mode;
    assign rc_o       = dec_q.ctl.rc;
    assign upd_o      = dec_q.ctl.upd;
    assign len_o      = dec_q.ctl.len;
endmodule

// File: rtl/idec_chk.sv
module idec_chk
    import idec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      op_o,
    input logic            wr_en_o,
    input logic [4:0]      wr_reg_o,
    input logic            rd1_en_o,
    input logic [4:0]      rd1_reg_o,
    input logic            rd2_en_o,
    input logic [4:0]      rd2_reg_o,
    input logic            rd3_en_o,
    input logic [4:0]      rd3_reg_o,
    input logic [XLEN-1:0] imm_o,
    input logic [2:0]      imm_mode_o,
    input logic            rc_o,
    input logic            upd_o,
    input logic [3:0]      len_o
);
    logic any_en;
    logic is_mem;

    assign any_en = wr_en_o | rd1_en_o | rd2_en_o | rd3_en_o;
    assign is_mem = (op_o == OP_LOAD) || (op_o == OP_STORE);

    assert_store_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OP_STORE) |-> (!wr_en_o && rd3_en_o && rd1_en_o));

    assert_load_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OP_LOAD) |-> (wr_en_o && rd1_en_o && !rd3_en_o));

    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OP_ILLEGAL) |-> (!any_en && imm_o == '0 && imm_mode_o == IMM_NONE
                                  && !rc_o && !upd_o && len_o == 4'd0));

    assert_nop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_o == OP_NOP) |-> (!any_en && imm_o == '0 && !rc_o && !upd_o));

    assert_rc_alu_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rc_o |-> (op_o == OP_ADD || op_o == OP_AND || op_o == OP_OR));

    assert_len_mem_only_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !is_mem |-> (len_o == 4'd0 && !upd_o));

    assert_len_values_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_mem |-> (len_o == 4'd1 || len_o == 4'd2 || len_o == 4'd4));

    assert_upd_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (len_o == 4'd4 && rd1_en_o));

    assert_ulo_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_mode_o == IMM_ULO) |-> ((imm_o >> 16) == '0));

    assert_shi_extend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_mode_o == IMM_SHI) |-> (imm_o[15:0] == 16'h0
                                     && imm_o == XLEN'($signed(imm_o[31:0]))));

    assert_slo_extend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_mode_o == IMM_SLO) |-> (imm_o == XLEN'($signed(imm_o[15:0]))));

    assert_none_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_mode_o == IMM_NONE) |-> (imm_o == '0));

    assert_idle_port_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en_o || wr_reg_o == 5'd0) && (rd1_en_o || rd1_reg_o == 5'd0)
         && (rd2_en_o || rd2_reg_o == 5'd0) && (rd3_en_o || rd3_reg_o == 5'd0)));

    assert_reset_clears_R12: assert property (@(posedge clk)
        !rst_n |=> (op_o == OP_NOP && !any_en && imm_o == '0 && len_o == 4'd0));
endmodule

bind idec_top idec_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_o       (op_o),
    .wr_en_o    (wr_en_o),
    .wr_reg_o   (wr_reg_o),
    .rd1_en_o   (rd1_en_o),
    .rd1_reg_o  (rd1_reg_o),
    .rd2_en_o   (rd2_en_o),
    .rd2_reg_o  (rd2_reg_o),
    .rd3_en_o   (rd3_en_o),
    .rd3_reg_o  (rd3_reg_o),
    .imm_o      (imm_o),
    .imm_mode_o (imm_mode_o),
    .rc_o       (rc_o),
    .upd_o      (upd_o),
    .len_o      (len_o)
);

// File: tb/tb_idec_top.sv
`timescale 1ns/1ps
module tb_idec_top;

    typedef struct {
        logic [2:0]  op;
        logic        wr_en;
        logic [4:0]  wr;
        logic        r1_en;
        logic [4:0]  r1;
        logic        r2_en;
        logic [4:0]  r2;
        logic        r3_en;
        logic [4:0]  r3;
        logic [63:0] imm;
        logic [2:0]  mode;
        logic        rc;
        logic        upd;
        logic [3:0]  len;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = 32'h0;
    logic        be = 1'b1;

    logic [2:0]  op_o;
    logic        wr_en_o, rd1_en_o, rd2_en_o, rd3_en_o;
    logic [4:0]  wr_reg_o, rd1_reg_o, rd2_reg_o, rd3_reg_o;
    logic [63:0] imm_o;
    logic [2:0]  imm_mode_o;
    logic        rc_o, upd_o;
    logic [3:0]  len_o;

    int   n_run  = 0;
    int   n_fail = 0;
    exp_t q[$];
    logic [31:0] lf = 32'h1D2C_3B4A;

    always #2 clk = ~clk;

    idec_top dut (
        .clk(clk), .rst_n(rst_n), .insn_i(insn), .big_endian_i(be),
        .op_o(op_o), .wr_en_o(wr_en_o), .wr_reg_o(wr_reg_o),
        .rd1_en_o(rd1_en_o), .rd1_reg_o(rd1_reg_o),
        .rd2_en_o(rd2_en_o), .rd2_reg_o(rd2_reg_o),
        .rd3_en_o(rd3_en_o), .rd3_reg_o(rd3_reg_o),
        .imm_o(imm_o), .imm_mode_o(imm_mode_o),
        .rc_o(rc_o), .upd_o(upd_o), .len_o(len_o)
    );

    function automatic logic [99:0] sig(exp_t e);
        return {e.op, e.wr_en, e.wr, e.r1_en, e.r1, e.r2_en, e.r2,
                e.r3_en, e.r3, e.imm, e.mode, e.rc, e.upd, e.len};
    endfunction

    function automatic exp_t actual();
        exp_t a;
        a.op = op_o; a.wr_en = wr_en_o; a.wr = wr_reg_o;
        a.r1_en = rd1_en_o; a.r1 = rd1_reg_o; a.r2_en = rd2_en_o; a.r2 = rd2_reg_o;
        a.r3_en = rd3_en_o; a.r3 = rd3_reg_o; a.imm = imm_o; a.mode = imm_mode_o;
        a.rc = rc_o; a.upd = upd_o; a.len = len_o; a.tag = "";
        return a;
    endfunction

    function automatic exp_t blank(string tag, logic [2:0] op);
        exp_t e;
        e.op = op; e.wr_en = 0; e.wr = 0; e.r1_en = 0; e.r1 = 0; e.r2_en = 0; e.r2 = 0;
        e.r3_en = 0; e.r3 = 0; e.imm = 0; e.mode = 0; e.rc = 0; e.upd = 0; e.len = 0;
        e.tag = tag;
        return e;
    endfunction

    function automatic logic [31:0] dw(int opc, logic [4:0] t, logic [4:0] a, logic [15:0] im);
        return {opc[5:0], t, a, im};
    endfunction

    function automatic logic [31:0] xw(int xo, logic [4:0] t, logic [4:0] a, logic [4:0] b, logic r);
        return {6'd31, t, a, b, xo[9:0], r};
    endfunction

    function automatic logic [63:0] sx16(logic [15:0] v);
        return {{48{v[15]}}, v};
    endfunction

    task automatic rnd(output logic [31:0] v);
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        v = lf * 32'h9E37_79B9;
    endtask

    // Driver: present one logical word in the chosen byte order, queue its expectation.
    task automatic send(logic [31:0] w, logic big, exp_t e);
        @(negedge clk);
        be   = big;
        insn = big ? w : {w[7:0], w[15:8], w[23:16], w[31:24]};
        if (!big) e.tag = {e.tag, "/R1"};
        q.push_back(e);
    endtask

    // Monitor: output register updates at the rising edge after the drive.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                exp_t a;
                e = q.pop_front();
                a = actual();
                n_run++;
                if (sig(a) !== sig(e)) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", e.tag, sig(a), sig(e));
                end
            end
        end
    end

    task automatic chk_reset(string tag);
        exp_t z;
        z = blank(tag, 3'd0);
        n_run++;
        if (sig(actual()) !== sig(z)) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, sig(actual()), sig(z));
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        exp_t e;
        // R12: reset holds outputs at zero even with a live instruction on the input
        repeat (3) @(negedge clk);
        insn = dw(14, 5'd3, 5'd4, 16'h8001);
        repeat (2) @(negedge clk);
        chk_reset("R12");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            logic big;
            big = i[0];
            // R4 / R3: add immediate, signed low and signed high
            for (int s = 0; s < 2; s++) begin
                rnd(r);
                e = blank(s == 0 ? "R4" : "R3", 3'd1);
                e.wr_en = 1; e.wr = r[25:21]; e.r1_en = 1; e.r1 = r[20:16];
                e.mode = (s == 0) ? 3'd3 : 3'd4;
                e.imm  = (s == 0) ? sx16(r[15:0]) : {{32{r[15]}}, r[15:0], 16'h0};
                send(dw(14 + s, r[25:21], r[20:16], r[15:0]), big, e);
            end
            // R5: or immediate / and immediate record
            for (int s = 0; s < 2; s++) begin
                logic [31:0] w;
                rnd(r);
                w = dw(s == 0 ? 24 : 28, r[25:21], r[20:16], r[15:0]);
                e = blank("R5", s == 0 ? 3'd3 : 3'd2);
                e.wr_en = 1; e.wr = r[20:16]; e.r3_en = 1; e.r3 = r[25:21];
                e.mode = 3'd1; e.imm = {48'h0, r[15:0]}; e.rc = (s == 1);
                if (w == 32'h6000_0000) e = blank("R6", 3'd0);
                send(w, big, e);
            end
            // R7: extended add / and / or, record bit from bit 0
            for (int k = 0; k < 3; k++) begin
                int xo;
                rnd(r);
                xo = (k == 0) ? 266 : (k == 1) ? 28 : 444;
                e = blank("R7", k == 0 ? 3'd1 : (k == 1 ? 3'd2 : 3'd3));
                e.r2_en = 1; e.r2 = r[15:11]; e.wr_en = 1; e.rc = r[0];
                if (k == 0) begin
                    e.wr = r[25:21]; e.r1_en = 1; e.r1 = r[20:16];
                end else begin
                    e.wr = r[20:16]; e.r3_en = 1; e.r3 = r[25:21];
                end
                send(xw(xo, r[25:21], r[20:16], r[15:11], r[0]), big, e);
            end
            // R8: displacement loads
            for (int k = 0; k < 4; k++) begin
                int opc;
                opc = (k == 0) ? 32 : (k == 1) ? 33 : (k == 2) ? 34 : 40;
                rnd(r);
                e = blank("R8", 3'd4);
                e.wr_en = 1; e.wr = r[25:21]; e.r1_en = 1; e.r1 = r[20:16];
                e.mode = 3'd3; e.imm = sx16(r[15:0]); e.upd = (opc == 33);
                e.len = (opc == 34) ? 4'd1 : (opc == 40) ? 4'd2 : 4'd4;
                send(dw(opc, r[25:21], r[20:16], r[15:0]), big, e);
            end
            // R9: displacement stores
            for (int k = 0; k < 4; k++) begin
                int opc;
                opc = (k == 0) ? 36 : (k == 1) ? 37 : (k == 2) ? 38 : 44;
                rnd(r);
                e = blank("R9", 3'd5);
                e.r3_en = 1; e.r3 = r[25:21]; e.r1_en = 1; e.r1 = r[20:16];
                e.mode = 3'd3; e.imm = sx16(r[15:0]); e.upd = (opc == 37);
                e.len = (opc == 38) ? 4'd1 : (opc == 44) ? 4'd2 : 4'd4;
                send(dw(opc, r[25:21], r[20:16], r[15:0]), big, e);
            end
            // R10: indexed word load / store, bit 0 forced high and ignored
            for (int k = 0; k < 2; k++) begin
                rnd(r);
                e = blank("R10", k == 0 ? 3'd4 : 3'd5);
                e.r1_en = 1; e.r1 = r[20:16]; e.r2_en = 1; e.r2 = r[15:11]; e.len = 4'd4;
                if (k == 0) begin
                    e.wr_en = 1; e.wr = r[25:21];
                end else begin
                    e.r3_en = 1; e.r3 = r[25:21];
                end
                send(xw(k == 0 ? 23 : 151, r[25:21], r[20:16], r[15:11], 1'b1), big, e);
            end
            // R11 / R2: unlisted primary and extended opcodes
            rnd(r);
            send({6'd0, r[25:0]}, big, blank("R11", 3'd7));
            send({6'd63, r[25:0]}, big, blank("R11", 3'd7));
            send(xw(999, r[25:21], r[20:16], r[15:11], r[0]), big, blank("R2", 3'd7));
            send(xw(0, r[25:21], r[20:16], r[15:11], r[0]), big, blank("R2", 3'd7));
        end

        // R6: the exact nop word in both byte orders, plus one-bit neighbours
        send(32'h6000_0000, 1'b1, blank("R6", 3'd0));
        send(32'h6000_0000, 1'b0, blank("R6", 3'd0));
        e = blank("R6", 3'd3);
        e.wr_en = 1; e.r3_en = 1; e.mode = 3'd1; e.imm = 64'h1;
        send(32'h6000_0001, 1'b1, e);
        e = blank("R6", 3'd3);
        e.wr_en = 1; e.wr = 5'd1; e.r3_en = 1; e.mode = 3'd1;
        send(32'h6001_0000, 1'b1, e);
        // R1: little-endian image of the nop presented as big-endian is an unlisted opcode
        send(32'h0000_0060, 1'b1, blank("R1", 3'd7));
        // R3: sign extension boundaries
        e = blank("R3", 3'd1);
        e.wr_en = 1; e.wr = 5'd2; e.r1_en = 1; e.r1 = 5'd3; e.mode = 3'd4;
        e.imm = 64'hFFFF_FFFF_8000_0000;
        send(dw(15, 5'd2, 5'd3, 16'h8000), 1'b1, e);
        e.mode = 3'd3; e.imm = 64'h0000_0000_0000_7FFF;
        send(dw(14, 5'd2, 5'd3, 16'h7FFF), 1'b1, e);
        // R13: after a memory op, an ALU op shows zero length and idle ports at zero
        e = blank("R13", 3'd1);
        e.wr_en = 1; e.wr = 5'd31; e.r1_en = 1; e.r1 = 5'd30; e.r2_en = 1; e.r2 = 5'd29;
        send(xw(266, 5'd31, 5'd30, 5'd29, 1'b0), 1'b1, e);

        repeat (4) @(negedge clk);
        // R12: reset again clears decoded outputs
        rst_n = 1'b0;
        insn  = dw(32, 5'd7, 5'd8, 16'h0010);
        repeat (2) @(negedge clk);
        chk_reset("R12");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule